// File: doc/BRIEF.md
# Split-Phit Operand Mesh Router

This block is one node of a two-dimensional mesh that moves short, single-flit operand messages between neighbouring tiles. Each message is carried as two phits on separate wires: a control phit with the destination coordinates and wake-up identifiers, and a data phit with the operand, an optional store address and status flags. The control phit is sent one cycle ahead of its data phit, so the receiving tile can start waking the consumer early. Route computation and arbitration look only at control phits. The data crossbar replays the select chosen for a control phit one cycle later, so data phits never need arbitration of their own.

The four compass inputs each have a control FIFO and a data FIFO. Each compass input has an on/off line back to its upstream neighbour. The local input has no buffering: a local control phit is either taken in the cycle it is offered or held by the sender, and its data phit follows in the cycle after it is taken. The local output always accepts. Each compass output is held while the downstream neighbour drives its on line low.

Top module: `phit_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every control-valid and data-valid output is low, `loc_accept` is low and all four `in_on` bits are high.
- R2: Ports are numbered 0 north, 1 south, 2 east, 3 west, 4 local. Control bits [2:0] give destination x and bits [5:3] give destination y. A message whose y is below the node's y leaves north, and one whose y is above leaves south. A message with equal y leaves east if its x is larger, west if its x is smaller, and local if both coordinates match.
- R3: When a control phit leaves an output in cycle T, the data phit of the same message leaves the same output in cycle T+1, and a data phit leaves no output in any other cycle.
- R4: Without contention, a control phit entering a compass input is visible on its output two cycles later, and a local control phit is visible one cycle after `loc_accept`.
- R5: `loc_accept` rises only in a cycle in which a local control phit is offered and wins its output. A phit that is not accepted stays with the sender and is not lost.
- R6: Inputs that contend for one output are served round-robin. When four compass inputs wait at once for the same output, the first four grants go to four different inputs.
- R7: A compass output issues a control phit only if its `out_on` bit was high in the cycle before the phit appears. Traffic for that output waits while the bit is low and resumes when it returns high.
- R8: `in_on[d]` is low whenever input d's control FIFO holds FIFO_DEPTH-1 or more entries. An upstream sender that obeys it loses nothing, and every message is delivered exactly once.
- R9: Messages from one input to one output leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cvld | input | 5 | Control phit valid, one bit per input port |
| in_ctrl | input | 5x29 | Control phit per input port |
| in_data | input | 5x109 | Data phit per input port, driven the cycle after its control phit |
| in_on | output | 4 | On/off back to each compass upstream neighbour |
| loc_accept | output | 1 | Local control phit taken this cycle |
| out_on | input | 4 | On/off from each compass downstream neighbour |
| out_cvld | output | 5 | Control phit valid per output port |
| out_ctrl | output | 5x29 | Control phit per output port |
| out_dvld | output | 5 | Data phit valid per output port |
| out_data | output | 5x109 | Data phit per output port |

## Verification
On one output, the control crossbar can send message k+1 in the same cycle that the data crossbar sends message k, so a fresh grant and a replayed select act together. This is provoked by loading several compass inputs with messages for the same output at once, and by long random runs with dense injection and on/off toggling. In each cycle, every data phit is judged against the tag of the control phit seen on that output one cycle earlier. The bench tracks each tag it injects and separately checks routing, ordering and exactly-once delivery.

// File: rtl/phit_router_pkg.sv
package phit_router_pkg;

    localparam int NPORT = 5;
    localparam int NDIR  = 4;

    typedef enum logic [2:0] {
        P_NORTH = 3'd0,
        P_SOUTH = 3'd1,
        P_EAST  = 3'd2,
        P_WEST  = 3'd3,
        P_LOCAL = 3'd4
    } port_e;

    // data phit contents: flags, optional store address, operand
    typedef struct packed {
        logic [4:0]  flags;
        logic [39:0] st_addr;
        logic [63:0] operand;
    } data_phit_t;

    localparam int DATA_PHIT_W = $bits(data_phit_t);
    localparam int CTRL_PHIT_W = 29;

    // Y first, then X
    function automatic port_e yx_pick(input int dx, input int dy,
                                      input int mx, input int my);
        if (dy < my)      return P_NORTH;
        else if (dy > my) return P_SOUTH;
        else if (dx > mx) return P_EAST;
        else if (dx < mx) return P_WEST;
        else              return P_LOCAL;
    endfunction

endpackage

// File: rtl/phit_fifo.sv
module phit_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/phit_rr_arb.sv
module phit_rr_arb #(
    parameter int N   = 5,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    logic [PW-1:0] ptr;

    always_comb begin
        bit found;
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // pointer moves just past the winner
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (gnt[i]) ptr <= (i == N - 1) ? '0 : PW'(i + 1);
            end
        end
    end

endmodule

// File: rtl/phit_xbar.sv
module phit_xbar #(
    parameter int W = 8,
    parameter int N = 5
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] din,
    output logic [W-1:0]        dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) dout = dout | din[i];
        end
    end

endmodule

// File: rtl/phit_router.sv
module phit_router
    import phit_router_pkg::*;
#(
    parameter int CTRL_W     = CTRL_PHIT_W,
    parameter int DATA_W     = DATA_PHIT_W,
    parameter int FIFO_DEPTH = 4,
    parameter int COORD_W    = 3,
    parameter int MY_X       = 2,
    parameter int MY_Y       = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0]              in_cvld,
    input  logic [NPORT-1:0][CTRL_W-1:0]  in_ctrl,
    input  logic [NPORT-1:0][DATA_W-1:0]  in_data,
    output logic [NDIR-1:0]               in_on,
    output logic                          loc_accept,
    input  logic [NDIR-1:0]               out_on,
    output logic [NPORT-1:0]              out_cvld,
    output logic [NPORT-1:0][CTRL_W-1:0]  out_ctrl,
    output logic [NPORT-1:0]              out_dvld,
    output logic [NPORT-1:0][DATA_W-1:0]  out_data
);

    localparam int LW       = $clog2(FIFO_DEPTH + 1);
    localparam int ON_LIMIT = FIFO_DEPTH - 1;

    logic [NDIR-1:0]                 dpush_q;
    logic [NDIR-1:0]                 dpop;
    logic [NDIR-1:0][LW-1:0]         clevel, dlevel;
    logic [NPORT-1:0]                head_v;
    logic [NPORT-1:0][CTRL_W-1:0]    head_c;
    logic [NPORT-1:0][DATA_W-1:0]    head_d;
    logic [NPORT-1:0][NPORT-1:0]     route_oh;   // [input][output]
    logic [NPORT-1:0][NPORT-1:0]     req_oi;     // [output][input]
    logic [NPORT-1:0][NPORT-1:0]     gnt_oi;     // [output][input]
    logic [NPORT-1:0][NPORT-1:0]     sel_q;      // [output][input], one cycle late
    logic [NPORT-1:0]                taken;
    logic [NPORT-1:0][CTRL_W-1:0]    xc_out;
    logic [NPORT-1:0][DATA_W-1:0]    xd_out;

    // compass input buffers
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        phit_fifo #(.W(CTRL_W), .DEPTH(FIFO_DEPTH)) u_cfifo (
            .clk(clk), .rst(rst),
            .push(in_cvld[d]), .din(in_ctrl[d]),
            .pop(taken[d]), .dout(head_c[d]), .level(clevel[d])
        );
        phit_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_dfifo (
            .clk(clk), .rst(rst),
            .push(dpush_q[d]), .din(in_data[d]),
            .pop(dpop[d]), .dout(head_d[d]), .level(dlevel[d])
        );
        assign head_v[d] = (clevel[d] != '0);
        assign in_on[d]  = (clevel[d] < LW'(ON_LIMIT)) &&
                           (dlevel[d] < LW'(FIFO_DEPTH));
    end

    // local input is passed straight through
    assign head_v[P_LOCAL] = in_cvld[P_LOCAL];
    assign head_c[P_LOCAL] = in_ctrl[P_LOCAL];
    assign head_d[P_LOCAL] = in_data[P_LOCAL];

    // data phit of a compass input lands one cycle behind its control phit
    always_ff @(posedge clk) begin
        if (rst) dpush_q <= '0;
        else     dpush_q <= in_cvld[NDIR-1:0];
    end

    // route computation on control phits
    for (genvar i = 0; i < NPORT; i++) begin : g_route
        always_comb begin
            port_e p;
            p = yx_pick(int'(head_c[i][COORD_W-1:0]),
                        int'(head_c[i][2*COORD_W-1:COORD_W]), MY_X, MY_Y);
            route_oh[i]    = '0;
            route_oh[i][p] = 1'b1;
        end
    end

    // requests, gated by downstream on/off on compass outputs
    for (genvar o = 0; o < NPORT; o++) begin : g_req
        for (genvar i = 0; i < NPORT; i++) begin : g_in
            if (o == NPORT - 1) begin : g_loc
                assign req_oi[o][i] = head_v[i] & route_oh[i][o];
            end else begin : g_cmp
                assign req_oi[o][i] = head_v[i] & route_oh[i][o] & out_on[o];
            end
        end
    end

    // per-output round-robin and the two crossbars
    for (genvar o = 0; o < NPORT; o++) begin : g_out
        phit_rr_arb #(.N(NPORT)) u_arb (
            .clk(clk), .rst(rst), .req(req_oi[o]), .gnt(gnt_oi[o])
        );
        phit_xbar #(.W(CTRL_W), .N(NPORT)) u_cxbar (
            .sel(gnt_oi[o]), .din(head_c), .dout(xc_out[o])
        );
        phit_xbar #(.W(DATA_W), .N(NPORT)) u_dxbar (
            .sel(sel_q[o]), .din(head_d), .dout(xd_out[o])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                out_cvld[o] <= 1'b0;
                out_ctrl[o] <= '0;
                sel_q[o]    <= '0;
                out_dvld[o] <= 1'b0;
                out_data[o] <= '0;
            end else begin
                out_cvld[o] <= |gnt_oi[o];
                out_ctrl[o] <= xc_out[o];
                sel_q[o]    <= gnt_oi[o];
                out_dvld[o] <= |sel_q[o];
                out_data[o] <= xd_out[o];
            end
        end
    end

    always_comb begin
        taken = '0;
        dpop  = '0;
        for (int o = 0; o < NPORT; o++) begin
            taken = taken | gnt_oi[o];
            dpop  = dpop  | sel_q[o][NDIR-1:0];
        end
    end

    assign loc_accept = taken[P_LOCAL];

endmodule

// File: rtl/phit_router_chk.sv
module phit_router_chk
    import phit_router_pkg::*;
#(
    parameter int CTRL_W  = 29,
    parameter int COORD_W = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NPORT-1:0]             in_cvld,
    input logic                         loc_accept,
    input logic [NDIR-1:0]              out_on,
    input logic [NPORT-1:0]             out_cvld,
    input logic [NPORT-1:0][CTRL_W-1:0] out_ctrl,
    input logic [NPORT-1:0]             out_dvld
);

    logic [NPORT-1:0][COORD_W-1:0] ox, oy;
    for (genvar o = 0; o < NPORT; o++) begin : g_xy
        assign ox[o] = out_ctrl[o][COORD_W-1:0];
        assign oy[o] = out_ctrl[o][2*COORD_W-1:COORD_W];
    end

    // R2
    route_north_chk: assert property (@(posedge clk) disable iff (rst)
        out_cvld[P_NORTH] |-> (oy[P_NORTH] < COORD_W'(MY_Y)));
    // R2
    route_south_chk: assert property (@(posedge clk) disable iff (rst)
        out_cvld[P_SOUTH] |-> (oy[P_SOUTH] > COORD_W'(MY_Y)));
    // R2
    route_east_chk: assert property (@(posedge clk) disable iff (rst)
        out_cvld[P_EAST] |-> (oy[P_EAST] == COORD_W'(MY_Y) && ox[P_EAST] > COORD_W'(MY_X)));
    // R2
    route_west_chk: assert property (@(posedge clk) disable iff (rst)
        out_cvld[P_WEST] |-> (oy[P_WEST] == COORD_W'(MY_Y) && ox[P_WEST] < COORD_W'(MY_X)));
    // R2
    route_local_chk: assert property (@(posedge clk) disable iff (rst)
        out_cvld[P_LOCAL] |-> (oy[P_LOCAL] == COORD_W'(MY_Y) && ox[P_LOCAL] == COORD_W'(MY_X)));

    // R5
    loc_accept_offer_chk: assert property (@(posedge clk) disable iff (rst)
        loc_accept |-> in_cvld[P_LOCAL]);

    for (genvar o = 0; o < NPORT; o++) begin : g_port
        // R3
        data_follows_chk: assert property (@(posedge clk) disable iff (rst)
            out_cvld[o] |=> out_dvld[o]);
        // R3
        data_has_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
            out_dvld[o] |-> $past(out_cvld[o]));
        if (o < NDIR) begin : g_cmp
            // R7
            onoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
                out_cvld[o] |-> $past(out_on[o]));
        end
    end

endmodule

bind phit_router phit_router_chk #(
    .CTRL_W(CTRL_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
    .clk(clk), .rst(rst), .in_cvld(in_cvld), .loc_accept(loc_accept),
    .out_on(out_on), .out_cvld(out_cvld), .out_ctrl(out_ctrl), .out_dvld(out_dvld)
);

// File: tb/phit_router_bench.sv
module phit_router_bench;

    localparam int CW = 29;
    localparam int DW = 109;
    localparam int MX = 2;
    localparam int MY = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [4:0]          in_cvld = '0;
    logic [4:0][CW-1:0]  in_ctrl = '0;
    logic [4:0][DW-1:0]  in_data = '0;
    logic [3:0]          in_on;
    logic                loc_accept;
    logic [3:0]          out_on = 4'hF;
    logic [4:0]          out_cvld;
    logic [4:0][CW-1:0]  out_ctrl;
    logic [4:0]          out_dvld;
    logic [4:0][DW-1:0]  out_data;

    phit_router u_phit_router (
        .clk(clk), .rst(rst), .in_cvld(in_cvld), .in_ctrl(in_ctrl),
        .in_data(in_data), .in_on(in_on), .loc_accept(loc_accept),
        .out_on(out_on), .out_cvld(out_cvld), .out_ctrl(out_ctrl),
        .out_dvld(out_dvld), .out_data(out_data)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [CW-1:0] q [5][$];
    bit  sent [4096];
    bit  delivered [4096];
    int  sent_cyc [4096];
    int  last_tag [5][5];
    int  next_tag = 0;
    int  outstanding = 0;
    int  cyc = 0;
    bit  running = 1'b0;
    bit  lat_mode = 1'b0;
    bit  rr_mode = 1'b0;
    int  rr_order[$];
    int  port_deliv [5];
    logic [4:0] prev_cvld = '0;
    int  prev_tag [5];
    bit  dphase [4];
    int  dtag [4];
    bit  loc_dphase = 1'b0;
    int  loc_tag = 0;
    bit  loc_acc_seen = 1'b0;
    logic [3:0] on_drive = 4'hF;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] data_of(input int tag);
        logic [4:0]  f;
        logic [39:0] a;
        logic [63:0] v;
        f = 5'(tag);
        a = 40'(tag) * 40'd7 + 40'd1;
        v = (64'(tag) * 64'h9E37_79B9) ^ 64'h0123_4567_89AB_CDEF;
        return {f, a, v};
    endfunction

    // independent model of the routing rule
    function automatic int route_of(input logic [CW-1:0] c);
        int x, y;
        x = int'(c[2:0]);
        y = int'(c[5:3]);
        if (y != MY) return (y < MY) ? 0 : 1;
        if (x != MX) return (x > MX) ? 2 : 3;
        return 4;
    endfunction

    task automatic enq(input int src, input int x, input int y);
        logic [CW-1:0] c;
        c = '0;
        c[2:0]   = 3'(x);
        c[5:3]   = 3'(y);
        c[17:6]  = 12'(next_tag);
        c[20:18] = 3'(src);
        q[src].push_back(c);
        sent[next_tag] = 1'b1;
        next_tag++;
        outstanding++;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    // monitor then drive, once per cycle at the falling edge
    always @(negedge clk) begin
        if (running) begin
            for (int o = 0; o < 5; o++) begin
                if (out_dvld[o] || prev_cvld[o]) begin
                    check(out_dvld[o] && prev_cvld[o], "R3", "data phit one cycle after control",
                          longint'(out_dvld[o]), longint'(prev_cvld[o]));
                    if (out_dvld[o] && prev_cvld[o])
                        check(out_data[o] == data_of(prev_tag[o]), "R3", "data phit contents",
                              longint'(out_data[o][63:0]), longint'(data_of(prev_tag[o])));
                end
                prev_cvld[o] = out_cvld[o];
                if (out_cvld[o]) begin
                    int tag, src;
                    tag = int'(out_ctrl[o][17:6]);
                    src = int'(out_ctrl[o][20:18]);
                    prev_tag[o] = tag;
                    port_deliv[o]++;
                    check(route_of(out_ctrl[o]) == o, "R2", "Y-X output port", o, route_of(out_ctrl[o]));
                    check(sent[tag] && !delivered[tag], "R8", "exactly-once delivery", tag, tag);
                    delivered[tag] = 1'b1;
                    outstanding--;
                    check(tag > last_tag[src][o], "R9", "per-path order", tag, last_tag[src][o]);
                    last_tag[src][o] = tag;
                    if (o < 4)
                        check(out_on[o] == 1'b1, "R7", "sent while off", 0, 1);
                    if (lat_mode)
                        check(cyc - sent_cyc[tag] == ((src == 4) ? 1 : 2), "R4", "latency",
                              cyc - sent_cyc[tag], (src == 4) ? 1 : 2);
                    if (rr_mode) rr_order.push_back(src);
                end
            end

            out_on = on_drive;
            for (int d = 0; d < 4; d++) begin
                in_data[d] = dphase[d] ? data_of(dtag[d]) : '0;
                dphase[d]  = 1'b0;
                if (q[d].size() > 0 && in_on[d]) begin
                    logic [CW-1:0] c;
                    c = q[d].pop_front();
                    in_cvld[d] = 1'b1;
                    in_ctrl[d] = c;
                    sent_cyc[int'(c[17:6])] = cyc;
                    dphase[d] = 1'b1;
                    dtag[d]   = int'(c[17:6]);
                end else begin
                    in_cvld[d] = 1'b0;
                    in_ctrl[d] = '0;
                end
            end
            in_data[4] = loc_dphase ? data_of(loc_tag) : '0;
            loc_dphase = 1'b0;
            if (q[4].size() > 0) begin
                in_cvld[4] = 1'b1;
                in_ctrl[4] = q[4][0];
            end else begin
                in_cvld[4] = 1'b0;
                in_ctrl[4] = '0;
            end
            #5;
            if (loc_accept) begin
                check(in_cvld[4] == 1'b1, "R5", "accept without offer", 0, 1);
                loc_acc_seen = 1'b1;
                if (q[4].size() > 0) begin
                    loc_tag = int'(q[4][0][17:6]);
                    sent_cyc[loc_tag] = cyc;
                    loc_dphase = 1'b1;
                    void'(q[4].pop_front());
                end
            end
            cyc++;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
        end
    end

    initial begin
        int mask;
        void'($urandom(32'd20240917));
        for (int s = 0; s < 5; s++)
            for (int o = 0; o < 5; o++) last_tag[s][o] = -1;
        for (int o = 0; o < 5; o++) port_deliv[o] = 0;

        repeat (5) @(posedge clk);
        #2;
        // R1 during reset
        check(out_cvld == '0 && out_dvld == '0, "R1", "valids in reset", longint'({out_cvld, out_dvld}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        // R1 first cycle after reset
        check(out_cvld == '0 && out_dvld == '0, "R1", "valids after reset", longint'({out_cvld, out_dvld}), 0);
        check(in_on == 4'hF, "R1", "in_on after reset", longint'(in_on), 15);
        check(loc_accept == 1'b0, "R1", "loc_accept after reset", longint'(loc_accept), 0);
        running = 1'b1;

        // R4: uncontended latency, compass and local
        lat_mode = 1'b1;
        enq(0, 2, 2);
        enq(4, 4, 2);
        repeat (10) @(posedge clk);
        lat_mode = 1'b0;
        check(outstanding == 0, "R4", "directed messages delivered", outstanding, 0);

        // R6: four compass inputs contend for the local output
        rr_mode = 1'b1;
        for (int k = 0; k < 2; k++)
            for (int s = 0; s < 4; s++) enq(s, 2, 2);
        repeat (20) @(posedge clk);
        rr_mode = 1'b0;
        check(rr_order.size() == 8, "R6", "contending deliveries", rr_order.size(), 8);
        if (rr_order.size() == 8) begin
            mask = 0;
            for (int k = 0; k < 4; k++) mask |= (1 << rr_order[k]);
            check(mask == 15, "R6", "first round distinct inputs", mask, 15);
            mask = 0;
            for (int k = 4; k < 8; k++) mask |= (1 << rr_order[k]);
            check(mask == 15, "R6", "second round distinct inputs", mask, 15);
        end

        // R7, R8, R5: east held off
        on_drive = 4'b1011;
        @(posedge clk);
        port_deliv[2] = 0;
        loc_acc_seen  = 1'b0;
        for (int k = 0; k < 4; k++) enq(3, 4, 2);
        enq(4, 3, 2);
        repeat (12) @(posedge clk);
        #2;
        check(port_deliv[2] == 0, "R7", "east output while off", port_deliv[2], 0);
        check(in_on[3] == 1'b0, "R8", "west in_on with full buffer", longint'(in_on[3]), 0);
        check(loc_acc_seen == 1'b0, "R5", "local accepted toward blocked output", longint'(loc_acc_seen), 0);
        check(q[4].size() == 1, "R5", "local phit held by sender", q[4].size(), 1);
        on_drive = 4'hF;
        repeat (20) @(posedge clk);
        check(port_deliv[2] == 5, "R7", "east resumes", port_deliv[2], 5);
        check(outstanding == 0, "R8", "nothing lost after release", outstanding, 0);

        // random traffic with on/off toggling
        for (int n = 0; n < 1500; n++) begin
            @(posedge clk);
            if ($urandom % 100 < 45)
                enq(int'($urandom % 5), int'($urandom % 5), int'($urandom % 5));
            for (int d = 0; d < 4; d++) on_drive[d] = ($urandom % 100) < 80;
        end
        on_drive = 4'hF;
        repeat (400) @(posedge clk);
        check(outstanding == 0, "R8", "random run drained", outstanding, 0);
        check(q[0].size() + q[1].size() + q[2].size() + q[3].size() + q[4].size() == 0,
              "R5", "sender queues empty", q[4].size(), 0);

        done = 1'b1;
        summary();
    end

endmodule